// File: doc/BRIEF.md
# DMA Transfer State Sequencer

This block runs the bus cycles for one DMA channel once that channel has been granted. It raises a hold request when the channel is asked for service, waits for the hold acknowledge, and then steps through working states S1 to S4. Along the way it drives the address enable and the upper address byte with its strobe, puts out the lower address byte, and drives the memory and I/O read and write strobes. After each transfer it updates the current address and the word count. When the count runs out or an external end-of-process arrives, it applies the channel's end action.

A host loads the base and current address and count, sets the mode word, and clears the mask. Service can come from a hardware request line or from a software request bit. It runs in one of three service modes: single, block or demand. Each transfer is of one of three types: write, read or verify. A compressed-timing input drops one state from every transfer.

All control strobes are active high. Any polarity change belongs at the chip pins, outside this block.

Top module: `dma_xfer_seq`

## Requirements
- R1: While reset is high and after it is released, hrq, aen, dack, adstb, eop_out and all four strobes are low. mask is 1, tc_flag is 0, and cur_addr and cur_cnt are 0.
- R2: A request is dreq or the software request bit, and it counts only while mask is 0. A request raises hrq. A masked request is ignored. aen and dack stay low until hlda is seen.
- R3: S1 is one cycle with adstb high and db_out carrying address bits 15:8. It occurs at the start of every hold period and otherwise only when the previous transfer changed address bits 15:8.
- R4: With compressed low, each transfer takes S2, S3 and S4 when ready is high. With compressed high, each transfer takes S2 and S4. aen and dack are high throughout S1 to S4.
- R5: ready low at the end of S3 inserts wait states before S4. With compressed high, ready low at the end of S2 does the same. Waits continue until ready is high. A verify transfer ignores ready.
- R6: Mode bits 3:2 select the type: 00 verify, 01 write, 10 read. A write drives memw and ior. A read drives memr and iow. Verify drives no strobe. The read-side strobe (ior or memr) is high in S3, wait and S4, or only in wait and S4 when compressed. The write-side strobe is high in wait and S4.
- R7: Each transfer decrements cur_cnt and steps cur_addr by one. Mode bit 5 set means decrement the address, clear means increment. A loaded count N gives N+1 transfers. Terminal count is the transfer made with the count at 0.
- R8: Mode bits 7:6 select the service: 00 demand, 01 single, 10 block. Single drops hrq after every transfer. Block runs until the end. Demand also stops when the request is low at the end of S4.
- R9: At terminal count or external end, tc_flag is set, the software request is cleared and hrq drops. If mode bit 4 is set, the current registers reload from base and mask is unchanged. Otherwise mask is set and the current registers keep their final values.
- R10: eop_out is a one-cycle pulse in the cycle after the S4 that reaches terminal count.
- R11: eop_in is sampled during S1 to S4 and latched. The transfer in flight completes, and service then ends without an eop_out pulse.
- R12: ld_en writes base and current address and count together. mask_clr clears the mask. tc_clr clears tc_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dreq | input | 1 | Hardware request |
| sreq_set | input | 1 | Sets the software request bit |
| hlda | input | 1 | Hold acknowledge |
| ready | input | 1 | Low inserts wait states |
| eop_in | input | 1 | External end of process |
| mask_clr | input | 1 | Clears the mask |
| tc_clr | input | 1 | Clears tc_flag |
| ld_en | input | 1 | Load base and current registers |
| ld_addr | input | 16 | Address to load |
| ld_cnt | input | 16 | Count to load |
| mode | input | 6 | Mode word, bits 7:2 |
| compressed | input | 1 | Compressed timing |
| hrq | output | 1 | Hold request |
| dack | output | 1 | Acknowledge to the device |
| aen | output | 1 | Address enable |
| adstb | output | 1 | Upper address strobe |
| db_out | output | 8 | Upper address byte during S1 |
| addr_lo | output | 8 | Lower address byte |
| memr | output | 1 | Memory read strobe |
| memw | output | 1 | Memory write strobe |
| ior | output | 1 | I/O read strobe |
| iow | output | 1 | I/O write strobe |
| eop_out | output | 1 | Terminal count pulse |
| mask | output | 1 | Mask bit |
| tc_flag | output | 1 | Sticky end flag |
| cur_addr | output | 16 | Current address |
| cur_cnt | output | 16 | Current count |

## Verification
The bench counts address strobes and acknowledge cycles over runs whose addresses cross a 256-byte boundary in both directions. A sequencer that always ran S1, or never re-ran it, would show a wrong strobe count and a wrong total cycle count. It stalls a normal transfer on ready and checks that verify runs straight through, since a design that waited in verify would hang or add cycles. It drops the request in the middle of a demand run and checks the intermediate count before resuming, and it injects an external end during S1 so that a design that aborted the transfer early, or pulsed eop_out for it, is caught. Single-mode runs and autoinitialize runs then confirm that hrq releases after each transfer and that the mask and the reload behave as R9 requires.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_S0   = 3'd1,
    ST_S1   = 3'd2,
    ST_S2   = 3'd3,
    ST_S3   = 3'd4,
    ST_SW   = 3'd5,
    ST_S4   = 3'd6
  } seq_st_e;

  localparam logic [1:0] XT_VERIFY = 2'b00;
  localparam logic [1:0] XT_WRITE  = 2'b01;
  localparam logic [1:0] XT_READ   = 2'b10;

  localparam logic [1:0] SV_DEMAND = 2'b00;
  localparam logic [1:0] SV_SINGLE = 2'b01;
  localparam logic [1:0] SV_BLOCK  = 2'b10;
endpackage

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs #(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int LOW_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_cnt,
  input  logic          step,
  input  logic          reload,
  input  logic          dec,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output logic          cnt_zero,
  output logic          hi_change
);
  logic [AW-1:0] base_a, nxt_a;
  logic [CW-1:0] base_c;

  assign nxt_a     = dec ? cur_addr - 1'b1 : cur_addr + 1'b1;
  assign hi_change = nxt_a[AW-1:LOW_W] != cur_addr[AW-1:LOW_W];
  assign cnt_zero  = cur_cnt == '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_a   <= '0;
      base_c   <= '0;
      cur_addr <= '0;
      cur_cnt  <= '0;
    end else if (ld_en) begin
      base_a   <= ld_addr;
      base_c   <= ld_cnt;
      cur_addr <= ld_addr;
      cur_cnt  <= ld_cnt;
    end else if (reload) begin
      cur_addr <= base_a;
      cur_cnt  <= base_c;
    end else if (step) begin
      cur_addr <= nxt_a;
      cur_cnt  <= cur_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dreq,
  input  logic       sreq_set,
  input  logic       hlda,
  input  logic       ready,
  input  logic       eop_in,
  input  logic       mask_clr,
  input  logic       tc_clr,
  input  logic [1:0] svc,
  input  logic       verify,
  input  logic       autoi,
  input  logic       compressed,
  input  logic       cnt_zero,
  input  logic       hi_change,
  output seq_st_e    state,
  output logic       step,
  output logic       reload,
  output logic       hrq,
  output logic       mask,
  output logic       tc_flag,
  output logic       eop_out
);
  seq_st_e nxt;
  logic    sreq, eop_pend, any_req, req, rdy_ok, at_end, finish;

  assign any_req = dreq | sreq;
  assign req     = any_req & ~mask;
  assign rdy_ok  = ready | verify;
  assign at_end  = state == ST_S4;
  assign finish  = at_end & (cnt_zero | eop_pend | eop_in);
  assign step    = at_end;
  assign reload  = finish & autoi;
  assign hrq     = state != ST_IDLE;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (req) nxt = ST_S0;
      ST_S0:   nxt = !req ? ST_IDLE : (hlda ? ST_S1 : ST_S0);
      ST_S1:   nxt = ST_S2;
      ST_S2:   nxt = !compressed ? ST_S3 : (rdy_ok ? ST_S4 : ST_SW);
      ST_S3:   nxt = rdy_ok ? ST_S4 : ST_SW;
      ST_SW:   nxt = rdy_ok ? ST_S4 : ST_SW;
      ST_S4: begin
        if (finish || svc == SV_SINGLE)            nxt = ST_IDLE;
        else if (svc == SV_DEMAND && !any_req)     nxt = ST_IDLE;
        else                                       nxt = hi_change ? ST_S1 : ST_S2;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mask     <= 1'b1;
      tc_flag  <= 1'b0;
      sreq     <= 1'b0;
      eop_pend <= 1'b0;
      eop_out  <= 1'b0;
    end else begin
      state   <= nxt;
      eop_out <= at_end & cnt_zero;
      if (finish && !autoi) mask <= 1'b1;
      else if (mask_clr)    mask <= 1'b0;
      if (finish)           tc_flag <= 1'b1;
      else if (tc_clr)      tc_flag <= 1'b0;
      if (finish)           sreq <= 1'b0;
      else if (sreq_set)    sreq <= 1'b1;
      if (state == ST_IDLE || state == ST_S0 || at_end) eop_pend <= 1'b0;
      else if (eop_in)                                  eop_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_xfer_outs.sv
module dma_xfer_outs
  import dma_xfer_pkg::*;
#(
  parameter int AW    = 16,
  parameter int LOW_W = 8
) (
  input  seq_st_e             state,
  input  logic [1:0]          xtype,
  input  logic                compressed,
  input  logic [AW-1:0]       cur_addr,
  output logic                aen,
  output logic                dack,
  output logic                adstb,
  output logic [AW-LOW_W-1:0] db_out,
  output logic [LOW_W-1:0]    addr_lo,
  output logic                memr,
  output logic                memw,
  output logic                ior,
  output logic                iow
);
  logic working, rd_side, wr_side;

  assign working = state inside {ST_S1, ST_S2, ST_S3, ST_SW, ST_S4};
  assign aen     = working;
  assign dack    = working;
  assign adstb   = state == ST_S1;
  assign db_out  = adstb ? cur_addr[AW-1:LOW_W] : '0;
  assign addr_lo = working ? cur_addr[LOW_W-1:0] : '0;
  assign wr_side = state inside {ST_SW, ST_S4};
  assign rd_side = wr_side | (!compressed && state == ST_S3);

  assign ior  = rd_side && xtype == XT_WRITE;
  assign memw = wr_side && xtype == XT_WRITE;
  assign memr = rd_side && xtype == XT_READ;
  assign iow  = wr_side && xtype == XT_READ;
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_xfer_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int LOW_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dreq,
  input  logic                sreq_set,
  input  logic                hlda,
  input  logic                ready,
  input  logic                eop_in,
  input  logic                mask_clr,
  input  logic                tc_clr,
  input  logic                ld_en,
  input  logic [AW-1:0]       ld_addr,
  input  logic [CW-1:0]       ld_cnt,
  input  logic [7:2]          mode,
  input  logic                compressed,
  output logic                hrq,
  output logic                dack,
  output logic                aen,
  output logic                adstb,
  output logic [AW-LOW_W-1:0] db_out,
  output logic [LOW_W-1:0]    addr_lo,
  output logic                memr,
  output logic                memw,
  output logic                ior,
  output logic                iow,
  output logic                eop_out,
  output logic                mask,
  output logic                tc_flag,
  output logic [AW-1:0]       cur_addr,
  output logic [CW-1:0]       cur_cnt
);
  seq_st_e state;
  logic    step, reload, cnt_zero, hi_change;

  dma_xfer_regs #(.AW(AW), .CW(CW), .LOW_W(LOW_W)) u_regs (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_cnt(ld_cnt),
    .step(step), .reload(reload), .dec(mode[5]),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt), .cnt_zero(cnt_zero), .hi_change(hi_change)
  );

  dma_xfer_fsm u_fsm (
    .clk(clk), .rst(rst), .dreq(dreq), .sreq_set(sreq_set), .hlda(hlda),
    .ready(ready), .eop_in(eop_in), .mask_clr(mask_clr), .tc_clr(tc_clr),
    .svc(mode[7:6]), .verify(mode[3:2] == XT_VERIFY), .autoi(mode[4]),
    .compressed(compressed), .cnt_zero(cnt_zero), .hi_change(hi_change),
    .state(state), .step(step), .reload(reload), .hrq(hrq), .mask(mask),
    .tc_flag(tc_flag), .eop_out(eop_out)
  );

  dma_xfer_outs #(.AW(AW), .LOW_W(LOW_W)) u_outs (
    .state(state), .xtype(mode[3:2]), .compressed(compressed), .cur_addr(cur_addr),
    .aen(aen), .dack(dack), .adstb(adstb), .db_out(db_out), .addr_lo(addr_lo),
    .memr(memr), .memw(memw), .ior(ior), .iow(iow)
  );
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       hrq,
  input logic       aen,
  input logic       dack,
  input logic       adstb,
  input logic       memr,
  input logic       memw,
  input logic       ior,
  input logic       iow,
  input logic       eop_out,
  input logic       mask,
  input logic [7:2] mode
);
  // R6: a transfer never reads and writes the same side at once
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(memr && memw) && !(ior && iow));

  // R6: verify type drives no strobe
  p_verify_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (mode[3:2] == 2'b00) |-> !(memr || memw || ior || iow));

  // R3: the address strobe is a single cycle inside an acknowledged window
  p_adstb_in_win_r3: assert property (@(posedge clk) disable iff (rst)
    adstb |-> (aen && dack));
  p_adstb_single_r3: assert property (@(posedge clk) disable iff (rst)
    adstb |=> !adstb);

  // R2: bus outputs only under a hold request; a masked idle channel stays idle
  p_aen_needs_hold_r2: assert property (@(posedge clk) disable iff (rst)
    aen |-> hrq);
  p_masked_stays_r2: assert property (@(posedge clk) disable iff (rst)
    (!hrq && mask) |=> !hrq);

  // R10: end pulse is one cycle long
  p_eop_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    eop_out |=> !eop_out);

  // R9: end of service releases hold; without reload the mask is set
  p_end_release_r9: assert property (@(posedge clk) disable iff (rst)
    eop_out |-> !hrq);
  p_end_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (eop_out && !mode[4]) |-> mask);
endmodule

bind dma_xfer_seq dma_xfer_seq_chk u_chk (
  .clk(clk), .rst(rst), .hrq(hrq), .aen(aen), .dack(dack), .adstb(adstb),
  .memr(memr), .memw(memw), .ior(ior), .iow(iow), .eop_out(eop_out),
  .mask(mask), .mode(mode)
);

// File: tb/sim_dma_xfer_seq.sv
module sim_dma_xfer_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dreq = 1'b0, sreq_set = 1'b0, hlda, ready = 1'b1, eop_in = 1'b0;
  logic        mask_clr = 1'b0, tc_clr = 1'b0, ld_en = 1'b0, compressed = 1'b0;
  logic [15:0] ld_addr = '0, ld_cnt = '0;
  logic [7:2]  mode = '0;
  logic        hrq, dack, aen, adstb, memr, memw, ior, iow, eop_out, mask, tc_flag;
  logic [7:0]  db_out, addr_lo;
  logic [15:0] cur_addr, cur_cnt;
  logic        hold_block = 1'b0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  dma_xfer_seq u0 (
    .clk(clk), .rst(rst), .dreq(dreq), .sreq_set(sreq_set), .hlda(hlda),
    .ready(ready), .eop_in(eop_in), .mask_clr(mask_clr), .tc_clr(tc_clr),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_cnt(ld_cnt), .mode(mode),
    .compressed(compressed), .hrq(hrq), .dack(dack), .aen(aen), .adstb(adstb),
    .db_out(db_out), .addr_lo(addr_lo), .memr(memr), .memw(memw), .ior(ior),
    .iow(iow), .eop_out(eop_out), .mask(mask), .tc_flag(tc_flag),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt)
  );

  // host bus model: acknowledge follows the hold request one cycle later
  initial begin
    hlda = 1'b0;
    forever begin
      @(posedge clk);
      hlda <= hrq & ~hold_block;
    end
  end

  // free-running observers at the falling edge
  int n_adstb = 0, n_dack = 0, n_eop = 0;
  int r_memr = 0, r_memw = 0, r_ior = 0, r_iow = 0, r_hrq = 0;
  initial begin
    logic p_memr, p_memw, p_ior, p_iow, p_hrq;
    p_memr = 0; p_memw = 0; p_ior = 0; p_iow = 0; p_hrq = 0;
    forever begin
      @(negedge clk);
      if (adstb)   n_adstb++;
      if (dack)    n_dack++;
      if (eop_out) n_eop++;
      if (memr && !p_memr) r_memr++;
      if (memw && !p_memw) r_memw++;
      if (ior && !p_ior)   r_ior++;
      if (iow && !p_iow)   r_iow++;
      if (hrq && !p_hrq)   r_hrq++;
      p_memr = memr; p_memw = memw; p_ior = ior; p_iow = iow; p_hrq = hrq;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // stimulus and expected results: mode, addr, count, compressed, S1 count, dack cycles
  typedef struct packed {
    logic [7:0]  md;
    logic [15:0] a;
    logic [15:0] c;
    logic        comp;
    logic [7:0]  s1;
    logic [7:0]  dk;
  } vec_t;
  localparam vec_t VT [5] = '{
    '{8'h84, 16'h12FE, 16'd3, 1'b0, 8'd2, 8'd14},
    '{8'hB8, 16'h0501, 16'd2, 1'b1, 8'd2, 8'd8},
    '{8'h80, 16'h00FF, 16'd0, 1'b0, 8'd1, 8'd4},
    '{8'h44, 16'h2000, 16'd1, 1'b1, 8'd2, 8'd6},
    '{8'h18, 16'h30FF, 16'd2, 1'b0, 8'd2, 8'd11}
  };

  task automatic setup(input logic [7:0] md, input logic [15:0] a, input logic [15:0] c,
                       input logic comp);
    @(negedge clk);
    mode = md[7:2]; compressed = comp; ld_addr = a; ld_cnt = c;
    ld_en = 1'b1; mask_clr = 1'b1; tc_clr = 1'b1;
    @(negedge clk);
    ld_en = 1'b0; mask_clr = 1'b0; tc_clr = 1'b0;
  endtask

  task automatic wait_eop();
    do @(negedge clk); while (!eop_out);
    dreq = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "hrq", hrq, 0);
    chk("R1", "aen", aen, 0);
    chk("R1", "strobes", {memr, memw, ior, iow, adstb}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "mask", mask, 1);
    chk("R1", "tc_flag", tc_flag, 0);
    chk("R1", "cur_cnt", cur_cnt, 0);
    chk("R1", "eop_out", eop_out, 0);

    // R2: masked request ignored
    dreq = 1'b1;
    repeat (10) @(negedge clk);
    chk("R2", "masked hrq", hrq, 0);
    chk("R2", "masked aen", aen, 0);
    dreq = 1'b0;

    // table walk: R3 R4 R6 R7 R8 R9 R10
    for (int i = 0; i < 5; i++) begin
      int s_ad, s_dk, s_eop, s_mr, s_mw, s_ir, s_iw, s_hq, nx;
      logic [1:0] ty;
      logic [15:0] ea, ec;
      setup(VT[i].md, VT[i].a, VT[i].c, VT[i].comp);
      s_ad = n_adstb; s_dk = n_dack; s_eop = n_eop; s_mr = r_memr; s_mw = r_memw;
      s_ir = r_ior; s_iw = r_iow; s_hq = r_hrq;
      dreq = 1'b1;
      wait_eop();
      nx = int'(VT[i].c) + 1;
      ty = VT[i].md[3:2];
      if (VT[i].md[4]) begin ea = VT[i].a; ec = VT[i].c; end
      else begin
        ea = VT[i].md[5] ? VT[i].a - 16'(nx) : VT[i].a + 16'(nx);
        ec = 16'hFFFF;
      end
      chk("R3", "adstb cycles", n_adstb - s_ad, VT[i].s1);
      chk("R4", "dack cycles", n_dack - s_dk, VT[i].dk);
      chk("R6", "memr", r_memr - s_mr, (ty == 2'b10) ? nx : 0);
      chk("R6", "iow",  r_iow - s_iw,  (ty == 2'b10) ? nx : 0);
      chk("R6", "memw", r_memw - s_mw, (ty == 2'b01) ? nx : 0);
      chk("R6", "ior",  r_ior - s_ir,  (ty == 2'b01) ? nx : 0);
      chk("R7", "cur_addr", cur_addr, ea);
      chk("R7", "cur_cnt", cur_cnt, ec);
      chk("R8", "hold periods", r_hrq - s_hq, (VT[i].md[7:6] == 2'b01) ? nx : 1);
      chk("R9", "mask", mask, VT[i].md[4] ? 0 : 1);
      chk("R9", "tc_flag", tc_flag, 1);
      chk("R10", "eop pulses", n_eop - s_eop, 1);
    end

    // R2: no acknowledge means no bus cycles
    setup(8'h84, 16'h0010, 16'd0, 1'b0);
    hold_block = 1'b1;
    dreq = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2", "hrq waiting", hrq, 1);
    chk("R2", "aen before hlda", aen, 0);
    chk("R2", "dack before hlda", dack, 0);
    hold_block = 1'b0;
    wait_eop();

    // R3: upper byte shown during S1
    begin
      logic [7:0] seen;
      setup(8'h84, 16'hA5F0, 16'd0, 1'b0);
      dreq = 1'b1;
      do @(negedge clk); while (!adstb);
      seen = db_out;
      @(negedge clk);
      chk("R3", "db_out in S1", seen, 8'hA5);
      chk("R4", "addr_lo in S2", addr_lo, 8'hF0);
      wait_eop();
    end

    // R5: ready stall on a normal write
    begin
      int s_dk, s_mw;
      setup(8'h84, 16'h4000, 16'd0, 1'b0);
      s_dk = n_dack; s_mw = r_memw;
      ready = 1'b0;
      dreq = 1'b1;
      do @(negedge clk); while (!ior);
      repeat (2) @(negedge clk);
      ready = 1'b1;
      wait_eop();
      chk("R5", "dack cycles with 2 waits", n_dack - s_dk, 6);
      chk("R5", "memw pulses", r_memw - s_mw, 1);
    end

    // R5: verify ignores ready
    begin
      int s_dk;
      setup(8'h80, 16'h4100, 16'd0, 1'b0);
      s_dk = n_dack;
      ready = 1'b0;
      dreq = 1'b1;
      wait_eop();
      ready = 1'b1;
      chk("R5", "verify dack cycles", n_dack - s_dk, 4);
      chk("R5", "verify cur_cnt", cur_cnt, 16'hFFFF);
    end

    // R8: demand stops when request drops, then resumes
    setup(8'h04, 16'h5000, 16'd5, 1'b0);
    dreq = 1'b1;
    do @(negedge clk); while (!memw);
    dreq = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8", "demand paused hrq", hrq, 0);
    chk("R8", "demand paused cnt", cur_cnt, 4);
    chk("R8", "demand paused addr", cur_addr, 16'h5001);
    chk("R8", "demand paused tc_flag", tc_flag, 0);
    dreq = 1'b1;
    wait_eop();
    chk("R8", "demand resumed cnt", cur_cnt, 16'hFFFF);
    chk("R8", "demand resumed addr", cur_addr, 16'h5006);

    // R11: external end during S1
    begin
      int s_eop, s_mw;
      setup(8'h84, 16'h6000, 16'd10, 1'b0);
      s_eop = n_eop; s_mw = r_memw;
      dreq = 1'b1;
      do @(negedge clk); while (!adstb);
      eop_in = 1'b1;
      @(negedge clk);
      eop_in = 1'b0;
      do @(negedge clk); while (hrq);
      dreq = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11", "transfers done", r_memw - s_mw, 1);
      chk("R11", "cur_cnt", cur_cnt, 9);
      chk("R11", "cur_addr", cur_addr, 16'h6001);
      chk("R11", "tc_flag", tc_flag, 1);
      chk("R11", "mask", mask, 1);
      chk("R11", "no eop_out", n_eop - s_eop, 0);
    end

    // R9 / R12: software request with reload, then request cleared
    begin
      int s_hq;
      setup(8'h94, 16'h7000, 16'd0, 1'b0);
      s_hq = r_hrq;
      @(negedge clk);
      sreq_set = 1'b1;
      @(negedge clk);
      sreq_set = 1'b0;
      do @(negedge clk); while (!eop_out);
      repeat (10) @(negedge clk);
      chk("R9", "soft request one hold", r_hrq - s_hq, 1);
      chk("R9", "hrq after end", hrq, 0);
      chk("R9", "mask kept", mask, 0);
      chk("R12", "reloaded cnt", cur_cnt, 0);
      chk("R12", "reloaded addr", cur_addr, 16'h7000);
    end

    // R12: flag and mask controls
    @(negedge clk);
    tc_clr = 1'b1;
    @(negedge clk);
    tc_clr = 1'b0;
    chk("R12", "tc_clr", tc_flag, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule